// File: doc/BRIEF.md
# Multi-Core Private Peripheral Window Decoder

This block sits in front of the private peripherals of a cluster of up to four cores. It takes one access per cycle (address, write flag, write data, and the number of the requesting core) and decodes it within a 4 KB window. Only the low 12 address bits are decoded. The lowest 256 bytes hold a small snoop-control register file that is implemented here. All other mapped offsets are forwarded to one of the per-core interrupt-controller CPU interfaces or one of the per-core timer/watchdog pairs. The interrupt controller and the timers are outside this block.

Each peripheral kind can be reached in two ways. One window aliases the core that issues the access. A run of banked copies sits above it, and there the address picks the core. A strap-style input gives the number of cores present. Any bank whose computed core number is at or above that count is dropped without an error: reads return zero and writes have no effect. Offsets that map to nothing are flagged with an error.

Every access is answered exactly one cycle after it is presented. The answer carries the registered target selects, the offset within the target, the interrupt number of the selected timer, and a write strobe. When the access was routed, the read data is taken from the target's return bus in that response cycle.

Top module: `prv_window_decoder`

## Requirements
- R1: After reset, `rsp_vld`, `rsp_err`, `tgt_wr`, `ic_sel` and `tm_sel` are all zero, and the control register reads 0.
- R2: An access presented with `req_vld` high is answered by `rsp_vld` high in the next cycle. A cycle without `req_vld` gives `rsp_vld` low in the next cycle. Address bits above bit 11 have no effect on decoding.
- R3: The control register at offset 0x000 is read/write and stores only write-data bit 0. It reads back with bits 31:1 zero, and it changes only on a write to 0x000.
- R4: A read of offset 0x004 returns the present-core mask in bits 7:4 (bit 4+n set for each core n below the count) and (count − 1) in bits 1:0. Reads of 0x008 and 0x00C return zero. A write to 0x00C is accepted without error and changes nothing.
- R5: The access is flagged with `rsp_err` and returns zero read data, no select and no `tgt_wr` in these cases: offsets 0x010–0x0FF; any offset in 0x000–0x0FF other than 0x000, 0x004, 0x008 and 0x00C; writes to 0x004 or 0x008; offsets 0xB00–0xFFF.
- R6: Offsets 0x100–0x1FF select the interrupt CPU interface of the requesting core (`ic_sel` bit = `req_core`), with `ic_off` = offset bits 7:0.
- R7: Offsets 0x200–0x5FF select interrupt CPU interface number (offset − 0x200) >> 8.
- R8: Offsets 0x600–0x6FF select the requesting core's timer pair. Offsets 0x700–0xAFF select the pair of core (offset − 0x700) >> 8.
- R9: A timer access sets exactly one bit of `tm_sel`, at index core × 2 + address bit 5 (bit 5 = 1 means watchdog). It drives `tm_off` = address bits 3:0, and `tm_irq_id` = 29 for the timer or 30 for the watchdog. `tm_irq_id` is 0 when no timer is selected. At most one select bit is set across `ic_sel` and `tm_sel`.
- R10: A computed core number at or above the effective core count gives no select, no error, no `tgt_wr` and zero read data.
- R11: A routed read returns `tgt_rdata` on `rsp_rdata`. A routed write raises `tgt_wr` with `tgt_wdata` equal to the write data. Local, dropped and erroneous accesses never raise `tgt_wr`.
- R12: A `core_cnt` of 0 is treated as 1, and a value above 4 (the core parameter) is treated as 4. Each access uses the count presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address (low 12 bits decoded) |
| req_wdata | input | 32 | Write data |
| req_core | input | 2 | Number of the requesting core |
| core_cnt | input | 3 | Number of cores present |
| tgt_rdata | input | 32 | Read data returned by the selected target |
| rsp_vld | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped access |
| ic_sel | output | 4 | One-hot interrupt CPU interface select |
| ic_off | output | 8 | Offset within the interrupt CPU interface |
| tm_sel | output | 8 | One-hot timer/watchdog select (core × 2 + watchdog) |
| tm_off | output | 4 | Register offset within the timer pair |
| tm_irq_id | output | 5 | Private interrupt number of the selected timer |
| tgt_wr | output | 1 | Write strobe to the selected target |
| tgt_wdata | output | 32 | Write data to the selected target |

## Verification
Two pairs of functions can meet in the same cycle. The first is a control-register write followed at once by a read of that register: the response to the write and the decode of the read fall in the same cycle. The bench issues this pair back to back and expects the new bit in the read response. The second is a core-count change presented in the same cycle as a banked access. The bench repeats an identical banked address under two counts on consecutive accesses and expects the count from the access's own cycle to decide whether the access is routed or dropped.

// File: rtl/prv_pkg.sv
package prv_pkg;
    parameter int PRV_NCORE  = 4;
    parameter int PRV_CORE_W = $clog2(PRV_NCORE);
    parameter int PRV_OFF_W  = 12;
    parameter int PRV_IDX_W  = 4;

    // window layout (fixed by behaviour)
    localparam logic [PRV_OFF_W-1:0] WIN_IC_ALIAS = 12'h100;
    localparam logic [PRV_OFF_W-1:0] WIN_IC_BANK  = 12'h200;
    localparam logic [PRV_OFF_W-1:0] WIN_TM_ALIAS = 12'h600;
    localparam logic [PRV_OFF_W-1:0] WIN_TM_BANK  = 12'h700;
    localparam logic [PRV_OFF_W-1:0] WIN_END      = 12'hB00;

    localparam logic [PRV_OFF_W-1:0] REG_CTRL = 12'h000;
    localparam logic [PRV_OFF_W-1:0] REG_CFG  = 12'h004;
    localparam logic [PRV_OFF_W-1:0] REG_STAT = 12'h008;
    localparam logic [PRV_OFF_W-1:0] REG_INV  = 12'h00C;

    localparam logic [4:0] IRQ_TMR  = 5'd29;
    localparam logic [4:0] IRQ_WDOG = 5'd30;

    typedef enum logic [1:0] {
        SCU_NONE = 2'd0,
        SCU_CTRL = 2'd1,
        SCU_CFG  = 2'd2,
        SCU_ZERO = 2'd3
    } scu_kind_e;

    typedef struct packed {
        logic                  err;
        scu_kind_e             scu;
        logic                  ic_hit;
        logic                  tm_hit;
        logic [PRV_CORE_W-1:0] core;
        logic                  wdog;
        logic [7:0]            off;
    } dec_t;
endpackage

// File: rtl/prv_addr_decode.sv
module prv_addr_decode
    import prv_pkg::*;
#(
    parameter int NCORE = PRV_NCORE,
    localparam int CNT_W = $clog2(NCORE + 1)
) (
    input  logic [PRV_OFF_W-1:0]  off,
    input  logic                  wr,
    input  logic [PRV_CORE_W-1:0] core,
    input  logic [CNT_W-1:0]      eff_cnt,
    output dec_t                  dec
);
    logic [PRV_IDX_W-1:0] idx;
    logic                 routed;

    always_comb begin
        dec    = '0;
        idx    = '0;
        routed = 1'b0;
        if (off < WIN_IC_ALIAS) begin
            unique case (off)
                REG_CTRL: dec.scu = SCU_CTRL;
                REG_CFG:  if (wr) dec.err = 1'b1; else dec.scu = SCU_CFG;
                REG_STAT: if (wr) dec.err = 1'b1; else dec.scu = SCU_ZERO;
                REG_INV:  dec.scu = SCU_ZERO;
                default:  dec.err = 1'b1;
            endcase
        end else if (off < WIN_IC_BANK) begin
            dec.ic_hit = 1'b1;
            idx        = PRV_IDX_W'(core);
        end else if (off < WIN_TM_ALIAS) begin
            dec.ic_hit = 1'b1;
            idx        = off[11:8] - 4'd2;
        end else if (off < WIN_TM_BANK) begin
            dec.tm_hit = 1'b1;
            idx        = PRV_IDX_W'(core);
        end else if (off < WIN_END) begin
            dec.tm_hit = 1'b1;
            idx        = off[11:8] - 4'd7;
        end else begin
            dec.err = 1'b1;
        end
        routed = dec.ic_hit | dec.tm_hit;
        // banks past the configured count are dropped silently
        if (routed && (idx >= PRV_IDX_W'(eff_cnt))) begin
            dec.ic_hit = 1'b0;
            dec.tm_hit = 1'b0;
        end
        dec.core = idx[PRV_CORE_W-1:0];
        dec.wdog = off[5];
        dec.off  = off[7:0];
    end

    // R5: an error never coexists with a route
    always_comb begin
        assert_err_no_route_R5: assert (!(dec.err && (dec.ic_hit || dec.tm_hit)))
            else $error("error decode also routed");
    end
endmodule

// File: rtl/prv_scu_regs.sv
module prv_scu_regs
    import prv_pkg::*;
#(
    parameter int NCORE  = PRV_NCORE,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(NCORE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ctrl_wbit,
    input  scu_kind_e         kind,
    input  logic [CNT_W-1:0]  eff_cnt,
    output logic [DATA_W-1:0] rdata
);
    logic ctrl_d, ctrl_q;
    logic [DATA_W-1:0] cfg;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= 1'b0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        cfg = '0;
        cfg[4 +: NCORE]        = NCORE'((1 << eff_cnt) - 1);
        cfg[PRV_CORE_W-1:0]    = PRV_CORE_W'(eff_cnt - CNT_W'(1));
        unique case (kind)
            SCU_CTRL: rdata = DATA_W'(ctrl_q);
            SCU_CFG:  rdata = cfg;
            default:  rdata = '0;
        endcase
    end

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/prv_window_decoder.sv
module prv_window_decoder
    import prv_pkg::*;
#(
    parameter int NCORE  = PRV_NCORE,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(NCORE + 1),
    localparam int TM_N  = 2 * NCORE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_vld,
    input  logic                  req_wr,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [PRV_CORE_W-1:0] req_core,
    input  logic [CNT_W-1:0]      core_cnt,
    input  logic [DATA_W-1:0]     tgt_rdata,
    output logic                  rsp_vld,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_err,
    output logic [NCORE-1:0]      ic_sel,
    output logic [7:0]            ic_off,
    output logic [TM_N-1:0]       tm_sel,
    output logic [3:0]            tm_off,
    output logic [4:0]            tm_irq_id,
    output logic                  tgt_wr,
    output logic [DATA_W-1:0]     tgt_wdata
);
    typedef struct packed {
        logic              vld;
        logic              err;
        logic              rd_tgt;
        logic              wr_tgt;
        logic [DATA_W-1:0] data;
        logic [NCORE-1:0]  ic_sel;
        logic [TM_N-1:0]   tm_sel;
        logic [7:0]        off;
        logic [4:0]        irq;
        logic [DATA_W-1:0] wdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    dec_t dec;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] scu_rdata;
    logic              ctrl_we;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^req_addr[ADDR_W-1:PRV_OFF_W];

    always_comb begin
        if (core_cnt == '0)                   eff_cnt = CNT_W'(1);
        else if (core_cnt > CNT_W'(NCORE))    eff_cnt = CNT_W'(NCORE);
        else                                  eff_cnt = core_cnt;
    end

    prv_addr_decode #(.NCORE(NCORE)) u_dec (
        .off     (req_addr[PRV_OFF_W-1:0]),
        .wr      (req_wr),
        .core    (req_core),
        .eff_cnt (eff_cnt),
        .dec     (dec)
    );

    assign ctrl_we = req_vld && req_wr && (dec.scu == SCU_CTRL);

    prv_scu_regs #(.NCORE(NCORE), .DATA_W(DATA_W)) u_scu (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_wbit (req_wdata[0]),
        .kind      (dec.scu),
        .eff_cnt   (eff_cnt),
        .rdata     (scu_rdata)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = req_vld;
        if (req_vld) begin
            rsp_d.err = dec.err;
            if (!req_wr) rsp_d.data = scu_rdata;
            if (dec.ic_hit) begin
                rsp_d.ic_sel[dec.core] = 1'b1;
                rsp_d.off              = dec.off;
            end
            if (dec.tm_hit) begin
                rsp_d.tm_sel[{dec.core, dec.wdog}] = 1'b1;
                rsp_d.off = {4'b0, dec.off[3:0]};
                rsp_d.irq = dec.wdog ? IRQ_WDOG : IRQ_TMR;
            end
            if (dec.ic_hit || dec.tm_hit) begin
                rsp_d.rd_tgt = !req_wr;
                rsp_d.wr_tgt = req_wr;
                if (req_wr) rsp_d.wdata = req_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld   = rsp_q.vld;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rd_tgt ? tgt_rdata : rsp_q.data;
    assign ic_sel    = rsp_q.ic_sel;
    assign ic_off    = (|rsp_q.ic_sel) ? rsp_q.off : 8'h00;
    assign tm_sel    = rsp_q.tm_sel;
    assign tm_off    = rsp_q.off[3:0];
    assign tm_irq_id = rsp_q.irq;
    assign tgt_wr    = rsp_q.wr_tgt;
    assign tgt_wdata = rsp_q.wdata;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_sel, tm_sel}));
    assert_irq_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tm_sel) |-> (tm_irq_id == IRQ_TMR || tm_irq_id == IRQ_WDOG));
    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (ic_sel == '0 && tm_sel == '0 && !tgt_wr && rsp_rdata == '0));
    assert_bank_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> ((ic_sel >> $past(eff_cnt)) == '0 &&
                     (tm_sel >> (2 * $past(eff_cnt))) == '0));
    assert_wr_routed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> (ic_sel != '0 || tm_sel != '0));
endmodule

// File: tb/prv_window_decoder_tb_top.sv
module prv_window_decoder_tb_top;
    localparam logic [31:0] TGT = 32'hC0DE_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_wr = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_core = '0;
    logic [2:0]  core_cnt = 3'd4;
    logic [31:0] tgt_rdata = TGT;
    logic        rsp_vld, rsp_err, tgt_wr;
    logic [31:0] rsp_rdata, tgt_wdata;
    logic [3:0]  ic_sel, tm_off;
    logic [7:0]  ic_off, tm_sel;
    logic [4:0]  tm_irq_id;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prv_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
        .core_cnt(core_cnt), .tgt_rdata(tgt_rdata), .rsp_vld(rsp_vld),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ic_sel(ic_sel),
        .ic_off(ic_off), .tm_sel(tm_sel), .tm_off(tm_off),
        .tm_irq_id(tm_irq_id), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  core;
        logic [2:0]  cnt;
        logic        err;
        logic [3:0]  ic;
        logic [7:0]  tm;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h004, 32'h0, 2'd0, 3'd4, 1'b0, 4'h0, 8'h00, 32'hF3},
        '{1'b0, 32'h004, 32'h0, 2'd0, 3'd2, 1'b0, 4'h0, 8'h00, 32'h31},
        '{1'b0, 32'h004, 32'h0, 2'd0, 3'd1, 1'b0, 4'h0, 8'h00, 32'h10},
        '{1'b0, 32'h008, 32'h0, 2'd0, 3'd4, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h00C, 32'h0, 2'd0, 3'd4, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b1, 32'h00C, 32'hFFFF, 2'd0, 3'd4, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h010, 32'h0, 2'd0, 3'd4, 1'b1, 4'h0, 8'h00, 32'h0},
        '{1'b1, 32'h004, 32'h1, 2'd0, 3'd4, 1'b1, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'hB00, 32'h0, 2'd0, 3'd4, 1'b1, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'hFFC, 32'h0, 2'd0, 3'd4, 1'b1, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h104, 32'h0, 2'd2, 3'd4, 1'b0, 4'h4, 8'h00, TGT},
        '{1'b0, 32'h200, 32'h0, 2'd3, 3'd4, 1'b0, 4'h1, 8'h00, TGT},
        '{1'b0, 32'h5F0, 32'h0, 2'd0, 3'd4, 1'b0, 4'h8, 8'h00, TGT},
        '{1'b0, 32'h400, 32'h0, 2'd0, 3'd2, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h600, 32'h0, 2'd1, 3'd4, 1'b0, 4'h0, 8'h04, TGT},
        '{1'b0, 32'h620, 32'h0, 2'd1, 3'd4, 1'b0, 4'h0, 8'h08, TGT},
        '{1'b0, 32'h700, 32'h0, 2'd3, 3'd4, 1'b0, 4'h0, 8'h01, TGT},
        '{1'b0, 32'hA28, 32'h0, 2'd0, 3'd4, 1'b0, 4'h0, 8'h80, TGT},
        '{1'b0, 32'h924, 32'h0, 2'd0, 3'd3, 1'b0, 4'h0, 8'h20, TGT},
        '{1'b0, 32'h924, 32'h0, 2'd0, 3'd2, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h1234_5104, 32'h0, 2'd1, 3'd4, 1'b0, 4'h2, 8'h00, TGT},
        '{1'b0, 32'h604, 32'h0, 2'd3, 3'd2, 1'b0, 4'h0, 8'h00, 32'h0},
        '{1'b0, 32'h004, 32'h0, 2'd0, 3'd0, 1'b0, 4'h0, 8'h00, 32'h10},
        '{1'b0, 32'h004, 32'h0, 2'd0, 3'd7, 1'b0, 4'h0, 8'h00, 32'hF3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge with the response visible
    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic [1:0] c, input logic [2:0] n);
        req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        req_core = c; core_cnt = n;
        @(negedge clk);
    endtask

    task automatic idle();
        req_vld = 1'b0; req_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp_vld", {31'b0, rsp_vld}, 32'h0);
        check("R1 rsp_err", {31'b0, rsp_err}, 32'h0);
        check("R1 tgt_wr", {31'b0, tgt_wr}, 32'h0);
        check("R1 selects", {20'b0, ic_sel, tm_sel}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 32'h000, 32'h0, 2'd0, 3'd4);
        check("R1 ctrl after reset", rsp_rdata, 32'h0);
        check("R2 rsp_vld", {31'b0, rsp_vld}, 32'h1);
        idle();
        check("R2 idle rsp_vld", {31'b0, rsp_vld}, 32'h0);

        // table walk: R2 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].core, VEC[i].cnt);
            check($sformatf("R5 vec%0d err", i), {31'b0, rsp_err}, {31'b0, VEC[i].err});
            check($sformatf("R7 vec%0d ic_sel", i), {28'b0, ic_sel}, {28'b0, VEC[i].ic});
            check($sformatf("R9 vec%0d tm_sel", i), {24'b0, tm_sel}, {24'b0, VEC[i].tm});
            check($sformatf("R10 vec%0d rdata", i), rsp_rdata, VEC[i].rd);
            check($sformatf("R11 vec%0d tgt_wr", i), {31'b0, tgt_wr}, 32'h0);
        end
        idle();

        // R3 back-to-back write then read of the control register
        access(1'b1, 32'h000, 32'hFFFF_FFFF, 2'd0, 3'd4);
        check("R3 write no err", {31'b0, rsp_err}, 32'h0);
        access(1'b0, 32'h000, 32'h0, 2'd0, 3'd4);
        check("R3 read after write", rsp_rdata, 32'h1);
        // R4 write to 0x00C leaves control unchanged
        access(1'b1, 32'h00C, 32'h0, 2'd0, 3'd4);
        access(1'b0, 32'h000, 32'h0, 2'd0, 3'd4);
        check("R4 inv write ignored", rsp_rdata, 32'h1);
        // R5 rejected write to 0x004 leaves control unchanged too
        access(1'b1, 32'h004, 32'h0, 2'd0, 3'd4);
        check("R5 cfg write err", {31'b0, rsp_err}, 32'h1);
        access(1'b1, 32'h000, 32'hFFFF_FFFE, 2'd0, 3'd4);
        access(1'b0, 32'h000, 32'h0, 2'd0, 3'd4);
        check("R3 only bit0 stored", rsp_rdata, 32'h0);

        // R6 offset forwarding
        access(1'b0, 32'h1AB, 32'h0, 2'd0, 3'd4);
        check("R6 ic_off", {24'b0, ic_off}, 32'hAB);
        check("R6 ic_sel", {28'b0, ic_sel}, 32'h1);
        // R9 timer offset and interrupt numbers
        access(1'b0, 32'h62C, 32'h0, 2'd0, 3'd4);
        check("R9 tm_off wdog", {28'b0, tm_off}, 32'hC);
        check("R9 irq wdog", {27'b0, tm_irq_id}, 32'd30);
        access(1'b0, 32'h60C, 32'h0, 2'd0, 3'd4);
        check("R9 irq timer", {27'b0, tm_irq_id}, 32'd29);
        access(1'b0, 32'h008, 32'h0, 2'd0, 3'd4);
        check("R9 irq none", {27'b0, tm_irq_id}, 32'd0);

        // R11 routed write
        access(1'b1, 32'h700, 32'h0000_1234, 2'd2, 3'd4);
        check("R11 tgt_wr", {31'b0, tgt_wr}, 32'h1);
        check("R11 tgt_wdata", tgt_wdata, 32'h1234);
        check("R8 banked tm_sel", {24'b0, tm_sel}, 32'h01);
        // R10 dropped write and R5 erroneous write
        access(1'b1, 32'h900, 32'h0000_5555, 2'd0, 3'd2);
        check("R10 dropped no tgt_wr", {31'b0, tgt_wr}, 32'h0);
        check("R10 dropped no err", {31'b0, rsp_err}, 32'h0);
        access(1'b1, 32'hB04, 32'h0000_5555, 2'd0, 3'd4);
        check("R5 err no tgt_wr", {31'b0, tgt_wr}, 32'h0);
        idle();
        check("R2 final idle", {31'b0, rsp_vld}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule